// File: doc/BRIEF.md
# Register Window Save Controller

This block decides the outcome of a "save" on a windowed register file. When a save is requested it forms the candidate window pointer (the current pointer stepped down by one, wrapping within the configured window count). It then checks whether that step is allowed. If the step is allowed, it commits the candidate pointer. If not, it raises a trap request with a 9-bit trap type and leaves the pointer where it was.

The overflow test is chosen at build time by a parameter. In mask mode, each window has a bit in an invalid-window mask, and a set bit at the candidate index blocks the save. In counter mode, a zero count of saveable windows blocks the save. The resulting spill trap type is then assembled from a small state field, and which half of that field is used depends on whether any windows belong to another context. The register storage, the restore side and the trap dispatch are all outside this block. Every result is registered and appears for exactly one cycle per request.

Top module: `win_save_ctrl`

## Requirements
- R1: On a save that does not trap, `ptr_out` becomes `ptr_in - 1`, wrapping from 0 to `NWIN-1`, and `commit` is high.
- R2: With `COUNTER_MODE = 0`, a save traps when `win_invalid[candidate]` is 1, and `trap_code` is 9'h005.
- R3: On a trapping save, `ptr_out` equals the `ptr_in` given with the request and `commit` is low.
- R4: With `COUNTER_MODE = 1`, a save traps exactly when `free_cnt` is zero, whatever the value of `win_invalid`.
- R5: In counter mode with `foreign_cnt` nonzero, `trap_code` = 9'h080 | 9'h020 | (`spill_cfg[5:3]` placed at bits 4:2).
- R6: In counter mode with `foreign_cnt` zero, `trap_code` = 9'h080 | (`spill_cfg[2:0]` placed at bits 4:2).
- R7: Results appear on the clock edge that samples `save_req` and last one cycle. In a cycle after no request, `commit` and `trap_req` are low, `trap_code` is zero and `ptr_out` holds.
- R8: After reset, `ptr_out`, `commit`, `trap_req` and `trap_code` are all zero.
- R9: With `COUNTER_MODE = 0`, the values of `free_cnt`, `foreign_cnt` and `spill_cfg` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_req | input | 1 | One-cycle save request |
| ptr_in | input | $clog2(NWIN) | Current window pointer, below NWIN |
| win_invalid | input | NWIN | Per-window invalid mask (mask mode) |
| free_cnt | input | $clog2(NWIN) | Windows still saveable (counter mode) |
| foreign_cnt | input | $clog2(NWIN) | Windows owned by another context (counter mode) |
| spill_cfg | input | 6 | Spill selector: bits 2:0 for own context, 5:3 for other |
| ptr_out | output | $clog2(NWIN) | Registered window pointer after the save |
| commit | output | 1 | Pulse: the save was accepted and ptr_out moved |
| trap_req | output | 1 | Pulse: the save trapped |
| trap_code | output | 9 | Trap type, zero when no trap |

## Verification
Every result is due one register stage after its request: the request is driven on a falling edge and is captured on the next rising edge, so the bench reads `commit`, `trap_req`, `trap_code` and `ptr_out` on the falling edge that follows. The bench then holds the request low for one cycle and reads the outputs again on the next falling edge, which checks that the pulse has ended and the pointer is held. One instance is built in each mode, and both share all inputs. As a result, every pointer, mask and counter pattern drives both modes in the same cycle, and each mode's indifference to the other mode's inputs is checked at the ports.

// File: rtl/win_save_pkg.sv
package win_save_pkg;
    localparam int TT_W     = 9;
    localparam int SPCFG_W  = 6;

    typedef logic [TT_W-1:0] trap_t;

    localparam trap_t TT_OVERFLOW    = 9'h005;
    localparam trap_t TT_SPILL_BASE  = 9'h080;
    localparam trap_t TT_SPILL_OTHER = 9'h020;
endpackage

// File: rtl/win_ptr_dec.sv
module win_ptr_dec #(
    parameter int NWIN = 8,
    localparam int PW  = $clog2(NWIN)
) (
    input  logic [PW-1:0] cur,
    output logic [PW-1:0] prev
);
    localparam logic [PW-1:0] LAST = PW'(NWIN - 1);

    always_comb begin
        if (cur == '0) prev = LAST;
        else           prev = cur - 1'b1;
    end
endmodule

// File: rtl/win_ovf_check.sv
module win_ovf_check
    import win_save_pkg::*;
#(
    parameter int NWIN         = 8,
    parameter bit COUNTER_MODE = 1'b0,
    localparam int PW          = $clog2(NWIN)
) (
    input  logic [PW-1:0]      cand,
    input  logic [NWIN-1:0]    win_invalid,
    input  logic [PW-1:0]      free_cnt,
    input  logic [PW-1:0]      foreign_cnt,
    input  logic [SPCFG_W-1:0] spill_cfg,
    output logic               trap,
    output trap_t              code
);
    localparam int MEXT = 1 << PW;

    logic [MEXT-1:0] mask_ext;
    logic            mask_hit;
    logic            spill_hit;
    trap_t           spill_code;

    assign mask_ext = MEXT'(win_invalid);

    always_comb begin
        mask_hit  = mask_ext[cand];
        spill_hit = (free_cnt == '0);
        if (foreign_cnt != '0)
            spill_code = TT_SPILL_BASE | TT_SPILL_OTHER | {4'b0, spill_cfg[5:3], 2'b0};
        else
            spill_code = TT_SPILL_BASE | {4'b0, spill_cfg[2:0], 2'b0};

        if (COUNTER_MODE) begin
            trap = spill_hit;
            code = spill_code;
        end else begin
            trap = mask_hit;
            code = TT_OVERFLOW;
        end
    end
endmodule

// File: rtl/win_save_ctrl.sv
module win_save_ctrl
    import win_save_pkg::*;
#(
    parameter int NWIN         = 8,
    parameter bit COUNTER_MODE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      save_req,
    input  logic [$clog2(NWIN)-1:0]   ptr_in,
    input  logic [NWIN-1:0]           win_invalid,
    input  logic [$clog2(NWIN)-1:0]   free_cnt,
    input  logic [$clog2(NWIN)-1:0]   foreign_cnt,
    input  logic [5:0]                spill_cfg,
    output logic [$clog2(NWIN)-1:0]   ptr_out,
    output logic                      commit,
    output logic                      trap_req,
    output logic [8:0]                trap_code
);
    localparam int PW = $clog2(NWIN);
    localparam logic [PW-1:0] LAST = PW'(NWIN - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          commit;
        logic          trap;
        trap_t         code;
    } out_s;

    logic [PW-1:0] cand;
    logic          det_trap;
    trap_t         det_code;
    out_s          out_d, out_q;

    win_ptr_dec #(.NWIN(NWIN)) u_dec (
        .cur  (ptr_in),
        .prev (cand)
    );

    win_ovf_check #(.NWIN(NWIN), .COUNTER_MODE(COUNTER_MODE)) u_chk (
        .cand        (cand),
        .win_invalid (win_invalid),
        .free_cnt    (free_cnt),
        .foreign_cnt (foreign_cnt),
        .spill_cfg   (spill_cfg),
        .trap        (det_trap),
        .code        (det_code)
    );

    always_comb begin
        out_d        = out_q;
        out_d.commit = 1'b0;
        out_d.trap   = 1'b0;
        out_d.code   = '0;
        if (save_req) begin
            if (det_trap) begin
                out_d.trap = 1'b1;
                out_d.code = det_code;
                out_d.ptr  = ptr_in;
            end else begin
                out_d.commit = 1'b1;
                out_d.ptr    = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ptr_out   = out_q.ptr;
    assign commit    = out_q.commit;
    assign trap_req  = out_q.trap;
    assign trap_code = out_q.code;

    // R1: an accepted save lands one window below the requested pointer
    p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((ptr_out == LAST) ? ($past(ptr_in) == '0)
                                      : ($past(ptr_in) == ptr_out + 1'b1)));

    // R3: a trap keeps the pointer given with the request
    p_trap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (ptr_out == $past(ptr_in) && !commit));

    // R7: every request yields exactly one outcome in the next cycle
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> (commit ^ trap_req));

    // R7: no request, no pulse, pointer held
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !save_req |=> (!commit && !trap_req && trap_code == '0 && $stable(ptr_out)));

    generate
        if (COUNTER_MODE) begin : g_cnt_chk
            // R4: empty saveable count always spills, with the spill base set
            p_spill_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (save_req && free_cnt == '0) |=> (trap_req && trap_code[8:7] == 2'b01));
        end else begin : g_mask_chk
            // R2: mask-mode traps carry the overflow code
            p_ovf_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
                trap_req |-> (trap_code == TT_OVERFLOW));
        end
    endgenerate
endmodule

// File: tb/win_save_ctrl_tb_top.sv
`timescale 1ns/1ps
module win_save_ctrl_tb_top;
    localparam int NW = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_req = 1'b0;
    logic [PW-1:0] ptr_in = '0;
    logic [NW-1:0] win_invalid = '0;
    logic [PW-1:0] free_cnt = '0;
    logic [PW-1:0] foreign_cnt = '0;
    logic [5:0]    spill_cfg = '0;

    logic [PW-1:0] m_ptr, c_ptr;
    logic          m_com, c_com, m_trp, c_trp;
    logic [8:0]    m_tt, c_tt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    win_save_ctrl #(.NWIN(NW), .COUNTER_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .ptr_in(ptr_in),
        .win_invalid(win_invalid), .free_cnt(free_cnt), .foreign_cnt(foreign_cnt),
        .spill_cfg(spill_cfg), .ptr_out(m_ptr), .commit(m_com),
        .trap_req(m_trp), .trap_code(m_tt)
    );

    win_save_ctrl #(.NWIN(NW), .COUNTER_MODE(1'b1)) dut_cnt_i (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .ptr_in(ptr_in),
        .win_invalid(win_invalid), .free_cnt(free_cnt), .foreign_cnt(foreign_cnt),
        .spill_cfg(spill_cfg), .ptr_out(c_ptr), .commit(c_com),
        .trap_req(c_trp), .trap_code(c_tt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic apply(input int c, input int m, input int cs, input int ow, input int ws);
        int cand, mbit, ctrap, ccode, mp, cp;
        @(negedge clk);
        ptr_in = PW'(c); win_invalid = NW'(m); free_cnt = PW'(cs);
        foreign_cnt = PW'(ow); spill_cfg = 6'(ws); save_req = 1'b1;
        @(negedge clk);
        save_req = 1'b0;
        cand  = (c == 0) ? NW - 1 : c - 1;
        mbit  = (m >> cand) & 1;
        ctrap = (cs == 0) ? 1 : 0;
        if (ow != 0) ccode = 128 + 32 + ((ws >> 3) & 7) * 4;
        else         ccode = 128 + (ws & 7) * 4;
        // mask-mode instance: R1 R2 R3, and R9 since counters vary freely
        chk(mbit ? "R2/R9 mask trap" : "R2/R9 mask no trap", int'(m_trp), mbit);
        chk(mbit ? "R3 mask hold ptr" : "R1 mask new ptr", int'(m_ptr), mbit ? c : cand);
        chk(mbit ? "R3 mask commit low" : "R1 mask commit", int'(m_com), 1 - mbit);
        chk("R2 mask trap code", int'(m_tt), mbit ? 5 : 0);
        // counter-mode instance: R4 R5 R6, with the mask varying
        chk("R4 spill trap", int'(c_trp), ctrap);
        chk(ctrap ? "R3 spill hold ptr" : "R1 cnt new ptr", int'(c_ptr), ctrap ? c : cand);
        chk("R4 spill commit", int'(c_com), 1 - ctrap);
        chk(ow != 0 ? "R5 spill code other" : "R6 spill code own", int'(c_tt), ctrap ? ccode : 0);
        mp = int'(m_ptr); cp = int'(c_ptr);
        @(negedge clk);
        // R7: one-cycle pulse, pointer held
        chk("R7 idle mask pulse", int'(m_com) + int'(m_trp) + int'(m_tt), 0);
        chk("R7 idle cnt pulse", int'(c_com) + int'(c_trp) + int'(c_tt), 0);
        chk("R7 idle mask ptr", int'(m_ptr), mp);
        chk("R7 idle cnt ptr", int'(c_ptr), cp);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8 reset mask outs", int'(m_ptr) + int'(m_com) + int'(m_trp) + int'(m_tt), 0);
        chk("R8 reset cnt outs", int'(c_ptr) + int'(c_com) + int'(c_trp) + int'(c_tt), 0);
        // mask sweep: every pointer against every mask; counters derived from mask
        for (int c = 0; c < NW; c++)
            for (int m = 0; m < 256; m++)
                apply(c, m, m & 7, (m >> 3) & 3, (m >> 2) & 63);
        // counter sweep: pointers, zero and nonzero counts, all spill selectors
        for (int c = 0; c < NW; c++)
            for (int k = 0; k < 3; k++)
                for (int ow = 0; ow < 2; ow++)
                    for (int ws = 0; ws < 64; ws++)
                        apply(c, (ws & 1) ? 255 : 0, (k == 0) ? 0 : (k == 1 ? 1 : 5),
                              ow * 3, ws);
        finish_run();
    end
endmodule